// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer

This block runs access cycles to external asynchronous memory shared by several banks, all from one controller clock. A requester hands it a bank index, an address and a read/write flag over a valid/ready handshake. The sequencer then drives an active-low one-hot bank select, the address and an active-low read or write strobe. On reads it samples the data bus and returns the word with a one-cycle valid pulse. An acknowledge input lets a slow device hold the strobe low for longer. Write data is carried outside this block; only the write strobe timing is placed here.

Every bank has its own 12-bit setting on the configuration bus. It holds a strobe length in wait states, a count of cycles that address and select are held after a read, an idle count used when moving to another bank, and a bit that turns off access prediction. The sequencer stalls the handshake until the dead time needed after the previous access has passed. That dead time depends on the previous bank's setting, on whether the next access uses the same bank, and on whether it is a read or a write. Timing is counted only in whole controller clocks.

Top module: `amem_rd_seq`

## Requirements
- R1: A strobe (read or write) stays low for max(W,1) cycles when acknowledge is high, where W is the wait-state field in bits [4:0] of the bank's 12-bit slice `cfg_i[12*b +: 12]`.
- R2: Bank select (one-hot, active low, bit b for bank b) and address are valid in the cycle just before the strobe falls and unchanged while it is low; at most one select bit is low at any time.
- R3: After a read strobe rises, the select stays low for exactly H cycles, H being the read-hold field in bits [7:5] of that bank's slice.
- R4: Read data is sampled in the last low cycle of the read strobe and presented on `rdata_o` with `rdata_valid_o` high for exactly the first cycle the strobe is high; writes produce no valid pulse.
- R5: While `ack_i` is low the strobe stays low past its wait-state count, and it rises only after a cycle in which acknowledge was high and the count was met.
- R6: With the prediction-disable bit (bit 11 of the previous bank's slice) at 0, the gap after a read is H before a read to the same bank and H + I before a read to another bank, I being the idle field in bits [10:8].
- R7: After a read, the gap before any write is H + max(I,4), whatever the prediction-disable bit.
- R8: With the prediction-disable bit at 1, the gap after a read is H + 3 before a read to the same bank and H + max(I,3) before a read to another bank.
- R9: The number of high strobe cycles between one access's strobe rising and the next one's falling is at least the gap plus one (the address-setup cycle), and exactly that when the next request waits; after a write the gap is zero.
- R10: During reset and right after it, both strobes and all select bits are high, no valid pulse is given, and a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_i | input | NUM_BANKS*12 | Per-bank settings, 12 bits per bank |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken this cycle |
| req_bank_i | input | BANK_W | Target bank |
| req_addr_i | input | ADDR_W | Target address |
| req_write_i | input | 1 | 1 for write, 0 for read |
| bank_sel_n_o | output | NUM_BANKS | One-hot active-low bank select |
| addr_o | output | ADDR_W | Memory address |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| data_i | input | DATA_W | Memory data bus |
| ack_i | input | 1 | Acknowledge; low stretches the strobe |
| rdata_o | output | DATA_W | Captured read data |
| rdata_valid_o | output | 1 | One-cycle pulse with read data |

## Verification
The checks that run every cycle are local in time. They cover: strobe length against the selected bank's wait count, no strobe rising right after a low acknowledge, a stable select through the setup edge, a one-hot select, never both strobes low at once, and the data pulse lining up with the read strobe's rise. The spacing between accesses is different. It depends on the previous bank's setting, the next request's bank and its direction, so only the bench's request pairs show it. The bench measures the high strobe cycles for each mix of same or other bank, read or write, and prediction mode. The hold length after each read and the exact number of cycles an acknowledge stall adds are also measured by the scenarios.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int CFG_W = 12;
    localparam int GAP_W = 5;
    localparam int CNT_W = 5;
    localparam int SC_W  = 4;

    // Field positions inside one bank slice are relied on by software.
    typedef struct packed {
        logic       pred_off;   // [11]
        logic [2:0] idle;       // [10:8]
        logic [2:0] hold;       // [7:5]
        logic [4:0] wait_st;    // [4:0]
    } bank_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/amem_cfg_sel.sv
module amem_cfg_sel
    import amem_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [NUM_BANKS*CFG_W-1:0] cfg_flat_i,
    input  logic [BANK_W-1:0]          idx_i,
    output bank_cfg_t                  cfg_o
);

    bank_cfg_t slots [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
        assign slots[g] = bank_cfg_t'(cfg_flat_i[g*CFG_W +: CFG_W]);
    end

    always_comb begin
        cfg_o = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (idx_i == BANK_W'(i)) begin
                cfg_o = slots[i];
            end
        end
    end

endmodule

// File: rtl/amem_gap_calc.sv
module amem_gap_calc
    import amem_pkg::*;
(
    input  bank_cfg_t          prev_cfg_i,
    input  logic               has_prev_i,
    input  logic               prev_write_i,
    input  logic               same_bank_i,
    input  logic               next_write_i,
    output logic [GAP_W-1:0]   gap_o
);

    logic [GAP_W-1:0] hold_w;
    logic [GAP_W-1:0] idle_w;
    logic [GAP_W-1:0] idle_min4;
    logic [GAP_W-1:0] idle_min3;

    always_comb begin
        hold_w    = GAP_W'(prev_cfg_i.hold);
        idle_w    = GAP_W'(prev_cfg_i.idle);
        idle_min4 = (idle_w > GAP_W'(4)) ? idle_w : GAP_W'(4);
        idle_min3 = (idle_w > GAP_W'(3)) ? idle_w : GAP_W'(3);

        if (!has_prev_i || prev_write_i) begin
            gap_o = '0;
        end else if (next_write_i) begin
            gap_o = hold_w + idle_min4;
        end else if (!prev_cfg_i.pred_off) begin
            gap_o = same_bank_i ? hold_w : (hold_w + idle_w);
        end else begin
            gap_o = same_bank_i ? (hold_w + GAP_W'(3)) : (hold_w + idle_min3);
        end
    end

endmodule

// File: rtl/amem_rd_seq.sv
module amem_rd_seq
    import amem_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_BANKS*CFG_W-1:0] cfg_i,
    input  logic                       req_valid_i,
    output logic                       req_ready_o,
    input  logic [BANK_W-1:0]          req_bank_i,
    input  logic [ADDR_W-1:0]          req_addr_i,
    input  logic                       req_write_i,
    output logic [NUM_BANKS-1:0]       bank_sel_n_o,
    output logic [ADDR_W-1:0]          addr_o,
    output logic                       rd_n_o,
    output logic                       wr_n_o,
    input  logic [DATA_W-1:0]          data_i,
    input  logic                       ack_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic                       rdata_valid_o
);

    typedef struct packed {
        seq_state_e          st;
        logic [BANK_W-1:0]   bank;
        logic [ADDR_W-1:0]   addr;
        logic                wr;
        logic [CNT_W-1:0]    cnt;
        logic [SC_W-1:0]     sc;
        logic                has_prev;
        logic [DATA_W-1:0]   rdata;
        logic                rvalid;
    } seq_t;

    seq_t seq_d, seq_q;

    bank_cfg_t          cur_cfg;
    logic [GAP_W-1:0]   gap;
    logic [CNT_W-1:0]   wait_eff;
    logic               in_strobe;
    logic               strobe_done;
    logic               gap_met;
    logic               accept;
    logic               sel_on;

    amem_cfg_sel #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) cfg_sel_i (
        .cfg_flat_i (cfg_i),
        .idx_i      (seq_q.bank),
        .cfg_o      (cur_cfg)
    );

    amem_gap_calc gap_calc_i (
        .prev_cfg_i   (cur_cfg),
        .has_prev_i   (seq_q.has_prev || in_strobe),
        .prev_write_i (seq_q.wr),
        .same_bank_i  (req_bank_i == seq_q.bank),
        .next_write_i (req_write_i),
        .gap_o        (gap)
    );

    assign in_strobe = (seq_q.st == ST_STROBE);

    always_comb begin
        wait_eff    = (cur_cfg.wait_st == '0) ? CNT_W'(1) : cur_cfg.wait_st;
        strobe_done = in_strobe && ack_i &&
                      (({1'b0, seq_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, wait_eff});
        gap_met     = (GAP_W'(seq_q.sc) + GAP_W'(1)) >= gap;
        req_ready_o = ((seq_q.st == ST_IDLE) && gap_met) ||
                      (strobe_done && (gap == '0));
        accept      = req_valid_i && req_ready_o;
    end

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (seq_q.sc != '1) begin
                    seq_d.sc = seq_q.sc + SC_W'(1);
                end
                if (accept) begin
                    seq_d.st   = ST_SETUP;
                    seq_d.bank = req_bank_i;
                    seq_d.addr = req_addr_i;
                    seq_d.wr   = req_write_i;
                end
            end
            ST_SETUP: begin
                seq_d.st  = ST_STROBE;
                seq_d.cnt = '0;
            end
            ST_STROBE: begin
                if (strobe_done) begin
                    seq_d.has_prev = 1'b1;
                    seq_d.sc       = '0;
                    if (!seq_q.wr) begin
                        seq_d.rdata  = data_i;
                        seq_d.rvalid = 1'b1;
                    end
                    if (accept) begin
                        seq_d.st   = ST_SETUP;
                        seq_d.bank = req_bank_i;
                        seq_d.addr = req_addr_i;
                        seq_d.wr   = req_write_i;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end else if (seq_q.cnt != '1) begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        sel_on = (seq_q.st == ST_SETUP) || in_strobe ||
                 ((seq_q.st == ST_IDLE) && seq_q.has_prev && !seq_q.wr &&
                  (seq_q.sc < SC_W'(cur_cfg.hold)));
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        assign bank_sel_n_o[g] = !(sel_on && (seq_q.bank == BANK_W'(g)));
    end

    assign addr_o        = seq_q.addr;
    assign rd_n_o        = !(in_strobe && !seq_q.wr);
    assign wr_n_o        = !(in_strobe && seq_q.wr);
    assign rdata_o       = seq_q.rdata;
    assign rdata_valid_o = seq_q.rvalid;

endmodule

// File: rtl/amem_rd_seq_chk.sv
module amem_rd_seq_chk
    import amem_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [NUM_BANKS*CFG_W-1:0] cfg_i,
    input logic [NUM_BANKS-1:0]       bank_sel_n_o,
    input logic [ADDR_W-1:0]          addr_o,
    input logic                       rd_n_o,
    input logic                       wr_n_o,
    input logic                       ack_i,
    input logic                       rdata_valid_o
);

    logic [BANK_W-1:0] sel_idx;
    logic [4:0]        sel_wait;
    logic [4:0]        weff_q;
    logic [5:0]        lo_q;

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (!bank_sel_n_o[i]) sel_idx = BANK_W'(i);
        end
        sel_wait = cfg_i[int'(sel_idx)*CFG_W +: 5];
        if (sel_wait == '0) sel_wait = 5'd1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q   <= '0;
            weff_q <= '0;
        end else if (!rd_n_o || !wr_n_o) begin
            if (lo_q != '1) lo_q <= lo_q + 6'd1;
            weff_q <= sel_wait;
        end else begin
            lo_q <= '0;
        end
    end

    p_strobe_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_n_o) |-> (lo_q >= {1'b0, weff_q}));

    p_setup_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_n_o) |-> ($past(bank_sel_n_o) == bank_sel_n_o) &&
                          ($past(addr_o) == addr_o) && !(&bank_sel_n_o));

    p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~bank_sel_n_o));

    p_rvalid_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_valid_o |-> $rose(rd_n_o));

    p_ack_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_n_o) |-> $past(ack_i));

    p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!rd_n_o && !wr_n_o));

endmodule

bind amem_rd_seq amem_rd_seq_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_i         (cfg_i),
    .bank_sel_n_o  (bank_sel_n_o),
    .addr_o        (addr_o),
    .rd_n_o        (rd_n_o),
    .wr_n_o        (wr_n_o),
    .ack_i         (ack_i),
    .rdata_valid_o (rdata_valid_o)
);

// File: tb/amem_rd_seq_tb_top.sv
module amem_rd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] cfg;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  sel_n;
    logic [15:0] addr;
    logic        rd_n, wr_n;
    logic [15:0] data_bus;
    logic        ack = 1'b1;
    logic [15:0] rdata;
    logic        rvalid;

    int nvec = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    // bank slice: {pred_off, idle[2:0], hold[2:0], wait[4:0]}
    assign cfg = {1'b1, 3'd1, 3'd3, 5'd1,    // bank 3
                  1'b0, 3'd0, 3'd0, 5'd0,    // bank 2
                  1'b1, 3'd5, 3'd2, 5'd3,    // bank 1
                  1'b0, 3'd2, 3'd1, 5'd2};   // bank 0

    assign data_bus = !rd_n ? (addr ^ 16'h5A3C) : 16'hDEAD;

    amem_rd_seq dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cfg_i         (cfg),
        .req_valid_i   (req_valid),
        .req_ready_o   (req_ready),
        .req_bank_i    (req_bank),
        .req_addr_i    (req_addr),
        .req_write_i   (req_write),
        .bank_sel_n_o  (sel_n),
        .addr_o        (addr),
        .rd_n_o        (rd_n),
        .wr_n_o        (wr_n),
        .data_i        (data_bus),
        .ack_i         (ack),
        .rdata_o       (rdata),
        .rdata_valid_o (rvalid)
    );

    // port monitor, sampled on the falling clock edge
    int          cyc = 0;
    bit          prev_low = 1'b0;
    int          rise_cyc = 0, low_start = 0, low_len = 0, spacing = 0;
    int          hold_cnt = 0;
    bit          hold_trk = 1'b0;
    int          rv_cnt = 0, rv_cyc = -1;
    logic [15:0] rv_data = '0;
    logic [3:0]  prev_sel = '1, setup_sel = '1;
    logic [15:0] prev_addr = '0, setup_addr = '0;

    always @(negedge clk) begin
        bit now_low;
        cyc++;
        now_low = !rd_n || !wr_n;
        if (now_low && !prev_low) begin
            spacing    = cyc - rise_cyc;
            low_start  = cyc;
            setup_sel  = prev_sel;
            setup_addr = prev_addr;
            hold_trk   = 1'b0;
        end
        if (!now_low && prev_low) begin
            rise_cyc = cyc;
            low_len  = cyc - low_start;
            hold_trk = 1'b1;
            hold_cnt = 0;
        end
        if (hold_trk && !now_low) begin
            if (sel_n != 4'hF) hold_cnt++;
            else hold_trk = 1'b0;
        end
        if (rvalid) begin
            rv_cnt++;
            rv_cyc  = cyc;
            rv_data = rdata;
        end
        prev_low  = now_low;
        prev_sel  = sel_n;
        prev_addr = addr;
    end

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int b, input logic [15:0] a, input bit w);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = b[1:0];
        req_addr  = a;
        req_write = w;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 rd_n in reset", int'(rd_n), 1);
        check("R10 wr_n in reset", int'(wr_n), 1);
        check("R10 sel in reset", int'(sel_n), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 no rvalid", int'(rvalid), 0);
        check("R10 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_single(input int b, input logic [15:0] a,
                            input int exp_low, input int exp_hold);
        int rv0;
        rv0 = rv_cnt;
        send(b, a, 1'b0);
        settle();
        check("R1 read strobe length", low_len, exp_low);
        check("R3 select hold", hold_cnt, exp_hold);
        check("R2 setup select", int'(setup_sel), int'(~(4'b1 << b) & 4'hF));
        check("R2 setup address", int'(setup_addr), int'(a));
        check("R4 one valid pulse", rv_cnt - rv0, 1);
        check("R4 read data", int'(rv_data), int'(a ^ 16'h5A3C));
        check("R4 pulse on rise", rv_cyc, rise_cyc);
    endtask

    task automatic t_pair(input string req, input int b1, input bit w1,
                          input int b2, input bit w2, input int exp_sp);
        int rv0;
        rv0 = rv_cnt;
        send(b1, 16'h0100 + 16'(b1), w1);
        send(b2, 16'h0200 + 16'(b2), w2);
        settle();
        check(req, spacing, exp_sp);
        check("R4 pulses per read", rv_cnt - rv0, int'(!w1) + int'(!w2));
    endtask

    task automatic t_ack(input int extra, input int exp_low);
        ack = 1'b0;
        fork
            send(0, 16'h0777, 1'b0);
            begin
                while (rd_n) @(negedge clk);
                repeat (extra) @(negedge clk);
                ack = 1'b1;
            end
        join
        settle();
        check("R5 stretched strobe", low_len, exp_low);
    endtask

    task automatic t_write_len();
        send(1, 16'h0333, 1'b1);
        settle();
        check("R1 write strobe length", low_len, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_single(0, 16'h0123, 2, 1);
        t_single(1, 16'h0456, 3, 2);
        t_single(2, 16'h0789, 1, 0);   // R1: zero wait count acts as one
        t_single(3, 16'h0ABC, 1, 3);
        t_write_len();
        t_ack(5, 6);
        t_ack(0, 2);                   // R5: acknowledge returns before count met
        t_pair("R6 same bank read-read", 0, 1'b0, 0, 1'b0, 2);
        t_pair("R6 other bank read-read", 0, 1'b0, 1, 1'b0, 4);
        t_pair("R6 zero gap read-read", 2, 1'b0, 2, 1'b0, 1);
        t_pair("R7 read-write pred on", 0, 1'b0, 2, 1'b1, 6);
        t_pair("R7 read-write pred off", 3, 1'b0, 3, 1'b1, 8);
        t_pair("R8 same bank pred off", 1, 1'b0, 1, 1'b0, 6);
        t_pair("R8 other bank pred off", 1, 1'b0, 0, 1'b0, 8);
        t_pair("R8 other bank small idle", 3, 1'b0, 2, 1'b0, 7);
        t_pair("R9 write then read", 0, 1'b1, 1, 1'b0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule